// File: doc/BRIEF.md
# I2C Slave Interrupt and Request Status

This block holds the software-visible request flags and interrupt state of an I2C slave engine. The engine sends single-cycle pulses for five events: a byte was received, the master asked for a byte, the received byte was the first of a transfer, a start condition was seen, and a stop condition was seen. From these pulses the block keeps three request flags and three raw interrupt causes. The causes are data, start and stop. It drives one interrupt line that combines all enabled causes.

Software uses a small register port. Each access is one cycle. Reads are combinational from the address. The block has a mask register and a write-one-to-clear register for the causes. The flag register tells software whether to read the received byte or supply the next byte to send. Two strobe inputs report when software has read or written the slave data register, which sits outside this block. Bus sampling, start/stop detection and shifting also live outside.

Register map, 3-bit address, 3-bit data:

| Address | Access | Contents |
|---------|--------|----------|
| 0 | read | request flags |
| 1 | read/write | mask |
| 2 | read | raw causes |
| 3 | read | masked causes |
| 4 | write | clear |

Top module: `i2c_slv_irq_status`

## Requirements
- R1: After reset every register reads 0 and `irq_o` is 0. Reset is asserted asynchronously on `rst_n` low. The block leaves reset two clock edges after `rst_n` rises.
- R2: A `ev_rx_byte` pulse sets the receive-request flag. This flag is bit 0 at address 0. It reads 1 from the cycle after the pulse.
- R3: `ev_rx_byte` together with `ev_rx_first` also sets the first-byte flag, bit 2 at address 0. A `ev_rx_first` pulse without `ev_rx_byte` has no effect. The first-byte flag is never 1 while the receive-request flag is 0.
- R4: A `ev_tx_req` pulse sets the transmit-request flag, bit 1 at address 0.
- R5: A `dr_rd_stb` pulse clears the receive-request and first-byte flags. A `dr_wr_stb` pulse clears the transmit-request flag. A set event in the same cycle wins over the clear.
- R6: The raw causes are read at address 2. A start pulse sets bit 1 and a stop pulse sets bit 2.
- R7: The mask register at address 1 holds what was last written to it. Bits are data 0, start 1, stop 2. The raw causes read the same whatever the mask is.
- R8: Address 3 reads raw AND mask. `irq_o` is 1 exactly when that value is nonzero.
- R9: The data cause is raw bit 0. `ev_rx_byte` or `ev_tx_req` sets it. Writing 1 to a bit of address 4 clears that raw cause, and 0 bits leave their causes alone. An event for the same cause in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_rx_byte | input | 1 | Byte received pulse |
| ev_rx_first | input | 1 | Qualifies `ev_rx_byte` as first byte of a transfer |
| ev_tx_req | input | 1 | Master requested a byte |
| ev_start | input | 1 | Start condition seen |
| ev_stop | input | 1 | Stop condition seen |
| dr_rd_stb | input | 1 | Software read the data register |
| dr_wr_stb | input | 1 | Software wrote the data register |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 3 | Register write data |
| reg_rdata | output | 3 | Register read data, combinational on `reg_addr` |
| irq_o | output | 1 | Combined slave interrupt |

## Verification
The assertions accept any mix of event pulses, strobes and register writes in the same cycle. `ev_rx_first` may even arrive without `ev_rx_byte`. The checks hold because each flag and cause has a defined set-over-clear outcome. The main assumption is that inputs are stable around the rising edge, so the stimulus drives on the falling edge and drops everything right after the rising edge. The sweep covers every event combination with every strobe pair and every clear pattern, including the conflicting ones, under all eight mask values. Mask writes happen only between sweep rounds, so each write cycle carries exactly one register access.

// File: rtl/i2c_slv_irq_pkg.sv
package i2c_slv_irq_pkg;
  localparam int unsigned NCAUSE = 3;
  localparam int unsigned REG_W  = NCAUSE;
  localparam int unsigned ADDR_W = 3;

  localparam int unsigned CAUSE_DATA  = 0;
  localparam int unsigned CAUSE_START = 1;
  localparam int unsigned CAUSE_STOP  = 2;

  localparam int unsigned FLG_RREQ  = 0;
  localparam int unsigned FLG_TREQ  = 1;
  localparam int unsigned FLG_FIRST = 2;

  typedef enum logic [ADDR_W-1:0] {
    ADR_FLAGS = 3'd0,
    ADR_MASK  = 3'd1,
    ADR_RAW   = 3'd2,
    ADR_MIS   = 3'd3,
    ADR_CLR   = 3'd4
  } reg_adr_e;
endpackage

// File: rtl/slv_irq_cause.sv
module slv_irq_cause (
  input  logic clk,
  input  logic rst_n,
  input  logic evt,
  input  logic clr,
  input  logic mask_we,
  input  logic mask_wd,
  output logic raw_o,
  output logic mask_o
);
  logic raw_q, raw_d, raw_en;
  logic mask_q, mask_d, mask_en;

  always_comb begin
    raw_en = evt | clr;
    raw_d  = evt;           // event has priority over clear
    mask_en = mask_we;
    mask_d  = mask_wd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q  <= 1'b0;
      mask_q <= 1'b0;
    end else begin
      if (raw_en)  raw_q  <= raw_d;
      if (mask_en) mask_q <= mask_d;
    end
  end

  assign raw_o  = raw_q;
  assign mask_o = mask_q;

  assert_evt_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> raw_o);
  assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !evt) |=> !raw_o);
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !evt) |=> $stable(raw_o));
  assert_mask_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_we |=> $stable(mask_o));
endmodule

// File: rtl/slv_req_flags.sv
module slv_req_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic ev_rx_byte,
  input  logic ev_rx_first,
  input  logic ev_tx_req,
  input  logic dr_rd_stb,
  input  logic dr_wr_stb,
  output logic rreq_o,
  output logic treq_o,
  output logic first_o
);
  logic rreq_q, rreq_d, rreq_en;
  logic treq_q, treq_d, treq_en;
  logic first_q, first_d, first_en;
  logic first_set;

  always_comb begin
    first_set = ev_rx_byte & ev_rx_first;
    rreq_en   = ev_rx_byte | dr_rd_stb;
    rreq_d    = ev_rx_byte;
    first_en  = first_set | dr_rd_stb;
    first_d   = first_set;
    treq_en   = ev_tx_req | dr_wr_stb;
    treq_d    = ev_tx_req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rreq_q  <= 1'b0;
      treq_q  <= 1'b0;
      first_q <= 1'b0;
    end else begin
      if (rreq_en)  rreq_q  <= rreq_d;
      if (treq_en)  treq_q  <= treq_d;
      if (first_en) first_q <= first_d;
    end
  end

  assign rreq_o  = rreq_q;
  assign treq_o  = treq_q;
  assign first_o = first_q;

  assert_rx_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rx_byte |=> rreq_o);
  assert_first_in_rreq_R3: assert property (@(posedge clk) disable iff (!rst_n)
    first_o |-> rreq_o);
  assert_first_alone_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_rx_first && !ev_rx_byte && !dr_rd_stb) |=> $stable(first_o));
  assert_tx_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_tx_req |=> treq_o);
  assert_rd_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (dr_rd_stb && !ev_rx_byte) |=> (!rreq_o && !first_o));
  assert_wr_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (dr_wr_stb && !ev_tx_req) |=> !treq_o);
endmodule

// File: rtl/i2c_slv_irq_status.sv
module i2c_slv_irq_status
  import i2c_slv_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_rx_byte,
  input  logic              ev_rx_first,
  input  logic              ev_tx_req,
  input  logic              ev_start,
  input  logic              ev_stop,
  input  logic              dr_rd_stb,
  input  logic              dr_wr_stb,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic              irq_o
);
  // reset: asserted asynchronously, released on the clock
  logic rst_meta_q, rst_sync_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  logic              mask_we, clr_we;
  logic [NCAUSE-1:0] cause_evt, cause_clr, raw, mask, masked;
  logic              rreq, treq, first;

  always_comb begin
    mask_we = reg_wr && (reg_addr == ADR_MASK);
    clr_we  = reg_wr && (reg_addr == ADR_CLR);
    cause_evt              = '0;
    cause_evt[CAUSE_DATA]  = ev_rx_byte | ev_tx_req;
    cause_evt[CAUSE_START] = ev_start;
    cause_evt[CAUSE_STOP]  = ev_stop;
    cause_clr = clr_we ? reg_wdata : '0;
  end

  slv_req_flags u_flags (
    .clk        (clk),
    .rst_n      (rst_sync_q),
    .ev_rx_byte (ev_rx_byte),
    .ev_rx_first(ev_rx_first),
    .ev_tx_req  (ev_tx_req),
    .dr_rd_stb  (dr_rd_stb),
    .dr_wr_stb  (dr_wr_stb),
    .rreq_o     (rreq),
    .treq_o     (treq),
    .first_o    (first)
  );

  for (genvar i = 0; i < NCAUSE; i++) begin : g_cause
    slv_irq_cause u_cause (
      .clk    (clk),
      .rst_n  (rst_sync_q),
      .evt    (cause_evt[i]),
      .clr    (cause_clr[i]),
      .mask_we(mask_we),
      .mask_wd(reg_wdata[i]),
      .raw_o  (raw[i]),
      .mask_o (mask[i])
    );
  end

  assign masked = raw & mask;
  assign irq_o  = |masked;

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      ADR_FLAGS: begin
        reg_rdata[FLG_RREQ]  = rreq;
        reg_rdata[FLG_TREQ]  = treq;
        reg_rdata[FLG_FIRST] = first;
      end
      ADR_MASK: reg_rdata = mask;
      ADR_RAW:  reg_rdata = raw;
      ADR_MIS:  reg_rdata = masked;
      default:  reg_rdata = '0;
    endcase
  end

  assert_irq_needs_raw_R8: assert property (@(posedge clk) disable iff (!rst_sync_q)
    irq_o |-> (raw != '0));
  assert_irq_needs_mask_R8: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (mask == '0) |-> !irq_o);
  assert_start_sets_R6: assert property (@(posedge clk) disable iff (!rst_sync_q)
    ev_start |=> raw[CAUSE_START]);
  assert_stop_sets_R6: assert property (@(posedge clk) disable iff (!rst_sync_q)
    ev_stop |=> raw[CAUSE_STOP]);
  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_sync_q |-> !irq_o);
endmodule

// File: tb/i2c_slv_irq_status_test.sv
module i2c_slv_irq_status_test;
  localparam int PERIOD = 20;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ev_rx_byte = 1'b0, ev_rx_first = 1'b0, ev_tx_req = 1'b0;
  logic       ev_start = 1'b0, ev_stop = 1'b0;
  logic       dr_rd_stb = 1'b0, dr_wr_stb = 1'b0;
  logic       reg_wr = 1'b0;
  logic [2:0] reg_addr = 3'd0;
  logic [2:0] reg_wdata = 3'd0;
  logic [2:0] reg_rdata;
  logic       irq_o;

  int n_chk = 0;
  int n_bad = 0;

  // bench-side expected state
  logic m_rreq = 1'b0, m_treq = 1'b0, m_first = 1'b0;
  logic [2:0] m_raw = 3'd0, m_mask = 3'd0;

  always #(PERIOD/2) clk = ~clk;

  i2c_slv_irq_status uut (
    .clk(clk), .rst_n(rst_n),
    .ev_rx_byte(ev_rx_byte), .ev_rx_first(ev_rx_first), .ev_tx_req(ev_tx_req),
    .ev_start(ev_start), .ev_stop(ev_stop),
    .dr_rd_stb(dr_rd_stb), .dr_wr_stb(dr_wr_stb),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_o(irq_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic rd(input logic [2:0] a, output logic [2:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic check_all();
    logic [2:0] d;
    rd(3'd0, d);
    chk("R2 rx request flag", d[0], m_rreq);
    chk("R4 tx request flag", d[1], m_treq);
    chk("R3 first-byte flag", d[2], m_first);
    rd(3'd1, d);
    chk("R7 mask readback", d, m_mask);
    rd(3'd2, d);
    chk("R9 raw data cause", d[0], m_raw[0]);
    chk("R6 raw start/stop", d[2:1], m_raw[2:1]);
    rd(3'd3, d);
    chk("R8 masked causes", d, m_raw & m_mask);
    chk("R8 irq line", irq_o, (m_raw & m_mask) != 3'd0);
  endtask

  // one cycle of events, data strobes and a clear write
  task automatic step(input logic [4:0] ev, input logic [1:0] st, input logic [2:0] clr);
    @(negedge clk);
    {ev_stop, ev_start, ev_rx_first, ev_tx_req, ev_rx_byte} = ev;
    {dr_wr_stb, dr_rd_stb} = st;
    reg_wr = 1'b1; reg_addr = 3'd4; reg_wdata = clr;
    @(posedge clk);
    #1;
    {ev_stop, ev_start, ev_rx_first, ev_tx_req, ev_rx_byte} = '0;
    {dr_wr_stb, dr_rd_stb} = '0;
    reg_wr = 1'b0; reg_wdata = '0;
    // expected update, set beats clear (R5, R9)
    m_rreq  = ev[0] ? 1'b1 : (st[0] ? 1'b0 : m_rreq);
    m_first = (ev[0] && ev[2]) ? 1'b1 : (st[0] ? 1'b0 : m_first);
    m_treq  = ev[1] ? 1'b1 : (st[1] ? 1'b0 : m_treq);
    for (int i = 0; i < 3; i++) begin
      logic e;
      e = (i == 0) ? (ev[0] | ev[1]) : ev[2+i];
      m_raw[i] = e ? 1'b1 : (clr[i] ? 1'b0 : m_raw[i]);
    end
    check_all();
  endtask

  task automatic write_mask(input logic [2:0] m);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 3'd1; reg_wdata = m;
    @(posedge clk);
    #1 reg_wr = 1'b0; reg_wdata = '0;
    m_mask = m;
    check_all();
  endtask

  initial begin
    #(PERIOD * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [2:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1: everything zero after reset
    for (int a = 0; a < 5; a++) begin
      rd(a[2:0], d);
      chk("R1 reset register value", d, 0);
    end
    chk("R1 reset irq", irq_o, 0);

    // R5 directed: read strobe clears rx flags, write strobe clears tx flag
    step(5'b00101, 2'b00, 3'b000);
    step(5'b00010, 2'b00, 3'b000);
    step(5'b00000, 2'b01, 3'b000);
    rd(3'd0, d);
    chk("R5 read strobe clears rx and first flags", {d[2], d[0]}, 0);
    step(5'b00000, 2'b10, 3'b000);
    rd(3'd0, d);
    chk("R5 write strobe clears tx flag", d[1], 0);
    // R3 directed: first pulse alone changes nothing
    step(5'b00100, 2'b00, 3'b000);
    rd(3'd0, d);
    chk("R3 lone first pulse ignored", d, 0);

    // sweep every event/strobe/clear combination under every mask
    for (int m = 0; m < 8; m++) begin
      write_mask(m[2:0]);
      for (int ev = 0; ev < 32; ev++)
        for (int st = 0; st < 4; st++)
          for (int c = 0; c < 8; c++)
            step(ev[4:0], st[1:0], c[2:0]);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule